// File: doc/BRIEF.md
# Multi-Cycle Tiny RISC Processor

This block is a compact 32-bit processor core. It executes eight instructions: two register-register arithmetic operations, a word load, a word store, an absolute jump, a jump through a register, a branch on equality and a branch on a negative value. It is built to be small. One adder serves address generation, arithmetic, branch comparison and PC advance. A single word-wide memory port carries both instruction fetches and data accesses. A controller state machine drives the datapath through a fixed fetch, execute and PC-update sequence, asserting named control points in each phase.

The core holds a 32-entry register file in which entry 0 is fixed at zero. It also holds a program counter, an instruction register and a one-bit branch-taken flag. Memory sits outside the block. The address and write strobe leave the core, and read data returns combinationally in the same cycle. Every instruction takes exactly three clock cycles.

Top module: `tiny_mc_cpu`

## Requirements
- R1: A synchronous reset clears the PC to 0 and puts the controller in its fetch phase, so the first cycle after reset drives address 0 with the write strobe low.
- R2: Every instruction takes three cycles (fetch, execute, PC update). In the fetch cycle the core drives the PC as the address, keeps the write strobe low and captures the read data as the instruction. Instruction k after reset is therefore fetched k*3 cycles after reset is released.
- R3: Opcode 0x00 with function 0x21 writes R[rd] = R[rs] + R[rt], and with function 0x23 it writes R[rd] = R[rs] - R[rt]. Both results are modulo 2^32. The rs field is bits 25:21, rt is bits 20:16, rd is bits 15:11, the function is bits 5:0 and the opcode is bits 31:26.
- R4: Opcode 0x23 (load) reads the word at R[rs] + sign-extended bits 15:0 and writes it into R[rt].
- R5: Opcode 0x2B (store) writes R[rt] to address R[rs] + sign-extended bits 15:0. It asserts the write strobe for exactly one cycle and changes no register. No other instruction asserts the strobe.
- R6: Opcode 0x04 branches to the branch's own PC plus the sign-extended 16-bit offset (unscaled) when R[rs] equals R[rt]. Otherwise it continues at PC+4.
- R7: Opcode 0x01 with rt=0 takes the same branch when bit 31 of R[rs] is set. Otherwise it continues at PC+4.
- R8: Opcode 0x02 sets the PC to the top 4 bits of the current PC, followed by the 26-bit field in bits 25:0, followed by two zero bits.
- R9: Opcode 0x00 with function 0x08 sets the PC to R[rs].
- R10: Register 0 always reads as zero, and an instruction that names it as a destination leaves it unchanged.
- R11: Any other encoding changes no register and no memory, and it advances the PC by 4. So does every instruction that is not a jump or a taken branch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state updates on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| mem_addr | output | 32 | Byte address of the current memory access |
| mem_wdata | output | 32 | Store data (R[rt]) |
| mem_rdata | input | 32 | Read data, valid combinationally for mem_addr |
| mem_we | output | 1 | Write strobe; the word is written at the clock edge |

## Verification
Fetches fall on cycles that are multiples of three after reset is released. The bench samples mem_addr on the falling edge at cycle 0 (reset state), at cycle 3 (the second fetch) and at cycle 27, where the fetch after the equality branch reveals the branch decision. Store and load results are due at the clock edge that ends each execute cycle. The bench therefore runs a fixed 90-cycle window, which is longer than the longest path through the test program. Only after that window does it compare memory words against values computed from the operands. Write strobes are counted on falling edges, before the edge that commits them. Across 36 operand pairs, the sweep covers equal and unequal values, sign-bit patterns and carry and borrow wrap.

// File: rtl/tmc_pkg.sv
package tmc_pkg;

    parameter int XLEN = 32;
    parameter int NREG = 32;

    localparam logic [5:0] OPC_RTYPE  = 6'h00;
    localparam logic [5:0] OPC_REGIMM = 6'h01;
    localparam logic [5:0] OPC_JUMP   = 6'h02;
    localparam logic [5:0] OPC_BEQ    = 6'h04;
    localparam logic [5:0] OPC_LOAD   = 6'h23;
    localparam logic [5:0] OPC_STORE  = 6'h2B;

    localparam logic [5:0] FUN_ADDU = 6'h21;
    localparam logic [5:0] FUN_SUBU = 6'h23;
    localparam logic [5:0] FUN_JR   = 6'h08;

    typedef enum logic [1:0] {
        PH_FETCH = 2'd0,
        PH_EXEC  = 2'd1,
        PH_PCUP  = 2'd2
    } phase_e;

    typedef enum logic [3:0] {
        K_ADD, K_SUB, K_LOAD, K_STORE, K_JABS, K_JREG, K_BEQ, K_BNEG, K_NOP
    } kind_e;

    typedef enum logic [1:0] { BS_REG, BS_IMM, BS_FOUR } bsel_e;
    typedef enum logic [1:0] { PS_SUM, PS_ABS, PS_REG } psel_e;
    typedef enum logic [1:0] { TF_CLEAR, TF_EQUAL, TF_NEG } tsel_e;

    typedef struct packed {
        logic  ir_load;
        logic  addr_pc;
        logic  opa_pc;
        bsel_e opb_sel;
        logic  invert;
        logic  rf_write;
        logic  dst_rt;
        logic  wb_mem;
        logic  store;
        logic  pc_load;
        psel_e pc_sel;
        tsel_e take_sel;
    } ctl_t;

    typedef struct packed {
        logic [XLEN-1:0] pc;
        logic [XLEN-1:0] ir;
        logic            taken;
    } arch_t;

    function automatic kind_e classify(input logic [5:0] opc,
                                       input logic [5:0] fun,
                                       input logic [4:0] rtf);
        kind_e k;
        k = K_NOP;
        case (opc)
            OPC_RTYPE: begin
                case (fun)
                    FUN_ADDU: k = K_ADD;
                    FUN_SUBU: k = K_SUB;
                    FUN_JR:   k = K_JREG;
                    default:  k = K_NOP;
                endcase
            end
            OPC_REGIMM: k = (rtf == 5'd0) ? K_BNEG : K_NOP;
            OPC_JUMP:   k = K_JABS;
            OPC_BEQ:    k = K_BEQ;
            OPC_LOAD:   k = K_LOAD;
            OPC_STORE:  k = K_STORE;
            default:    k = K_NOP;
        endcase
        return k;
    endfunction

endpackage

// File: rtl/tmc_adder.sv
module tmc_adder #(
    parameter int W = 32
) (
    input  logic [W-1:0] opa,
    input  logic [W-1:0] opb,
    input  logic         invert,
    output logic [W-1:0] sum
);
    logic [W-1:0] opb_eff;

    always_comb begin
        opb_eff = invert ? ~opb : opb;
        sum     = opa + opb_eff + {{(W-1){1'b0}}, invert};
    end
endmodule

// File: rtl/tmc_regfile.sv
module tmc_regfile #(
    parameter int NUM = 32,
    parameter int W   = 32
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [$clog2(NUM)-1:0] rd_a_idx,
    input  logic [$clog2(NUM)-1:0] rd_b_idx,
    input  logic                   wr_en,
    input  logic [$clog2(NUM)-1:0] wr_idx,
    input  logic [W-1:0]           wr_val,
    output logic [W-1:0]           rd_a_val,
    output logic [W-1:0]           rd_b_val
);
    localparam int IW = $clog2(NUM);

    logic [W-1:0] regs_q [NUM];
    logic [W-1:0] regs_d [NUM];

    always_comb begin
        for (int i = 0; i < NUM; i++) begin
            regs_d[i] = regs_q[i];
        end
        if (wr_en && (wr_idx != '0)) begin
            regs_d[wr_idx] = wr_val;
        end
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < NUM; i++) begin
            if (rst) regs_q[i] <= '0;
            else     regs_q[i] <= regs_d[i];
        end
    end

    always_comb begin
        rd_a_val = (rd_a_idx == IW'(0)) ? '0 : regs_q[rd_a_idx];
        rd_b_val = (rd_b_idx == IW'(0)) ? '0 : regs_q[rd_b_idx];
    end

    // R10
    zero_read_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_a_idx == '0) |-> (rd_a_val == '0));

    // R10
    zero_write_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_idx == '0 && rd_b_idx == '0) |=> (regs_q[0] == '0));
endmodule

// File: rtl/tmc_ctrl.sv
module tmc_ctrl
    import tmc_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic [5:0] opc,
    input  logic [5:0] fun,
    input  logic [4:0] rtf,
    input  logic   taken,
    output ctl_t   ctl,
    output phase_e phase
);
    phase_e phase_d, phase_q;
    kind_e  kind;

    always_comb begin
        kind    = classify(opc, fun, rtf);
        phase_d = phase_q;
        ctl     = '0;
        case (phase_q)
            PH_FETCH: begin
                ctl.addr_pc = 1'b1;
                ctl.ir_load = 1'b1;
                phase_d     = PH_EXEC;
            end
            PH_EXEC: begin
                ctl.opb_sel  = BS_REG;
                ctl.take_sel = TF_CLEAR;
                case (kind)
                    K_ADD: begin
                        ctl.rf_write = 1'b1;
                    end
                    K_SUB: begin
                        ctl.invert   = 1'b1;
                        ctl.rf_write = 1'b1;
                    end
                    K_LOAD: begin
                        ctl.opb_sel  = BS_IMM;
                        ctl.dst_rt   = 1'b1;
                        ctl.wb_mem   = 1'b1;
                        ctl.rf_write = 1'b1;
                    end
                    K_STORE: begin
                        ctl.opb_sel = BS_IMM;
                        ctl.store   = 1'b1;
                    end
                    K_BEQ: begin
                        ctl.invert   = 1'b1;
                        ctl.take_sel = TF_EQUAL;
                    end
                    K_BNEG: begin
                        ctl.take_sel = TF_NEG;
                    end
                    default: ;
                endcase
                phase_d = PH_PCUP;
            end
            PH_PCUP: begin
                ctl.addr_pc = 1'b1;
                ctl.opa_pc  = 1'b1;
                ctl.pc_load = 1'b1;
                ctl.opb_sel = taken ? BS_IMM : BS_FOUR;
                case (kind)
                    K_JABS:  ctl.pc_sel = PS_ABS;
                    K_JREG:  ctl.pc_sel = PS_REG;
                    default: ctl.pc_sel = PS_SUM;
                endcase
                phase_d = PH_FETCH;
            end
            default: phase_d = PH_FETCH;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) phase_q <= PH_FETCH;
        else     phase_q <= phase_d;
    end

    assign phase = phase_q;

    // R2
    fetch_to_exec_chk: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_FETCH) |=> (phase_q == PH_EXEC));

    // R2
    exec_to_pcup_chk: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_EXEC) |=> (phase_q == PH_PCUP));

    // R2
    pcup_to_fetch_chk: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_PCUP) |=> (phase_q == PH_FETCH));
endmodule

// File: rtl/tiny_mc_cpu.sv
module tiny_mc_cpu
    import tmc_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    output logic [31:0] mem_addr,
    output logic [31:0] mem_wdata,
    input  logic [31:0] mem_rdata,
    output logic        mem_we
);
    localparam int RIW = $clog2(NREG);

    arch_t  st_d, st_q;
    ctl_t   ctl;
    phase_e phase;

    logic [5:0]      f_opc, f_fun;
    logic [RIW-1:0]  f_rs, f_rt, f_rd;
    logic [15:0]     f_imm;
    logic [25:0]     f_tgt;
    logic [XLEN-1:0] imm_sx;
    logic [XLEN-1:0] rs_val, rt_val;
    logic [XLEN-1:0] add_a, add_b, add_sum;
    logic [RIW-1:0]  wr_idx;
    logic [XLEN-1:0] wr_val;

    always_comb begin
        f_opc  = st_q.ir[31:26];
        f_rs   = st_q.ir[25:21];
        f_rt   = st_q.ir[20:16];
        f_rd   = st_q.ir[15:11];
        f_imm  = st_q.ir[15:0];
        f_fun  = st_q.ir[5:0];
        f_tgt  = st_q.ir[25:0];
        imm_sx = {{(XLEN-16){f_imm[15]}}, f_imm};
    end

    tmc_ctrl u_ctrl (
        .clk   (clk),
        .rst   (rst),
        .opc   (f_opc),
        .fun   (f_fun),
        .rtf   (f_rt),
        .taken (st_q.taken),
        .ctl   (ctl),
        .phase (phase)
    );

    tmc_regfile #(.NUM(NREG), .W(XLEN)) u_rf (
        .clk      (clk),
        .rst      (rst),
        .rd_a_idx (f_rs),
        .rd_b_idx (f_rt),
        .wr_en    (ctl.rf_write),
        .wr_idx   (wr_idx),
        .wr_val   (wr_val),
        .rd_a_val (rs_val),
        .rd_b_val (rt_val)
    );

    always_comb begin
        add_a = ctl.opa_pc ? st_q.pc : rs_val;
        case (ctl.opb_sel)
            BS_IMM:  add_b = imm_sx;
            BS_FOUR: add_b = XLEN'(4);
            default: add_b = rt_val;
        endcase
    end

    tmc_adder #(.W(XLEN)) u_add (
        .opa    (add_a),
        .opb    (add_b),
        .invert (ctl.invert),
        .sum    (add_sum)
    );

    always_comb begin
        wr_idx    = ctl.dst_rt ? f_rt : f_rd;
        wr_val    = ctl.wb_mem ? mem_rdata : add_sum;
        mem_addr  = ctl.addr_pc ? st_q.pc : add_sum;
        mem_wdata = rt_val;
        mem_we    = ctl.store;
    end

    always_comb begin
        st_d = st_q;
        if (ctl.ir_load) begin
            st_d.ir = mem_rdata;
        end
        if (phase == PH_EXEC) begin
            case (ctl.take_sel)
                TF_EQUAL: st_d.taken = (add_sum == '0);
                TF_NEG:   st_d.taken = rs_val[XLEN-1];
                default:  st_d.taken = 1'b0;
            endcase
        end
        if (ctl.pc_load) begin
            case (ctl.pc_sel)
                PS_ABS:  st_d.pc = {st_q.pc[31:28], f_tgt, 2'b00};
                PS_REG:  st_d.pc = rs_val;
                default: st_d.pc = add_sum;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    // R2
    pc_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (phase != PH_PCUP) |=> $stable(st_q.pc));

    // R2
    ir_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (phase != PH_FETCH) |=> $stable(st_q.ir));

    // R5
    store_in_exec_chk: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> (phase == PH_EXEC));

    // R5
    store_no_rf_chk: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> !ctl.rf_write);

    // R2
    fetch_read_chk: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_FETCH) |-> (!mem_we && mem_addr == st_q.pc));
endmodule

// File: tb/sim_tiny_mc_cpu.sv
module sim_tiny_mc_cpu;
    localparam int CLK_PERIOD = 10;
    localparam int RUN_CYC    = 90;
    localparam logic [31:0] SENT = 32'hDEAD_BEEF;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;
    logic        mem_we;

    logic [31:0] mem [256];
    logic        tb_ld = 1'b0;
    logic [31:0] tb_la = '0;
    logic [31:0] tb_ld_d = '0;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    tiny_mc_cpu u0 (
        .clk       (clk),
        .rst       (rst),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_rdata (mem_rdata),
        .mem_we    (mem_we)
    );

    assign mem_rdata = mem[mem_addr[9:2]];

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (mem_we)     mem[mem_addr[9:2]] <= mem_wdata;
        else if (tb_ld) mem[tb_la[9:2]]    <= tb_ld_d;
    end

    function automatic logic [31:0] enc_r(input int rs, input int rt, input int rd, input logic [5:0] fn);
        return {6'h00, 5'(rs), 5'(rt), 5'(rd), 5'd0, fn};
    endfunction
    function automatic logic [31:0] enc_i(input logic [5:0] op, input int rs, input int rt, input logic [15:0] im);
        return {op, 5'(rs), 5'(rt), im};
    endfunction
    function automatic logic [31:0] enc_j(input logic [5:0] op, input logic [25:0] t);
        return {op, t};
    endfunction

    task automatic put_word(input logic [31:0] a, input logic [31:0] d);
        @(negedge clk);
        tb_la = a; tb_ld_d = d; tb_ld = 1'b1;
        @(negedge clk);
        tb_ld = 1'b0;
    endtask

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    initial begin
        while (cyc < 150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=%0d expected=<150000", cyc);
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        logic [31:0] vals [6];
        vals[0] = 32'h0000_0000; vals[1] = 32'h0000_0001; vals[2] = 32'h7FFF_FFFF;
        vals[3] = 32'h8000_0000; vals[4] = 32'hFFFF_FFFF; vals[5] = 32'h1234_5678;

        repeat (2) @(posedge clk);
        // program
        put_word(32'h00, enc_i(6'h23, 0, 1, 16'h0100));   // R4 lw r1
        put_word(32'h04, enc_i(6'h23, 0, 2, 16'h0104));   // R4 lw r2
        put_word(32'h08, enc_r(1, 2, 3, 6'h21));          // R3 addu
        put_word(32'h0C, enc_r(1, 2, 4, 6'h23));          // R3 subu
        put_word(32'h10, enc_i(6'h2B, 0, 3, 16'h0108));   // R5 sw
        put_word(32'h14, enc_i(6'h2B, 0, 4, 16'h010C));
        put_word(32'h18, enc_r(1, 2, 0, 6'h21));          // R10 write r0
        put_word(32'h1C, enc_i(6'h2B, 0, 0, 16'h0110));
        put_word(32'h20, enc_i(6'h04, 1, 2, 16'h0008));   // R6 beq -> 0x28
        put_word(32'h24, enc_i(6'h2B, 0, 1, 16'h0114));
        put_word(32'h28, enc_i(6'h01, 1, 0, 16'h0008));   // R7 bltz -> 0x30
        put_word(32'h2C, enc_i(6'h2B, 0, 2, 16'h0118));
        put_word(32'h30, enc_j(6'h02, 26'h10));           // R8 j 0x40
        put_word(32'h34, enc_i(6'h2B, 0, 1, 16'h011C));
        put_word(32'h38, enc_i(6'h2B, 0, 1, 16'h011C));
        put_word(32'h3C, enc_i(6'h2B, 0, 1, 16'h011C));
        put_word(32'h40, enc_i(6'h23, 0, 5, 16'h0120));
        put_word(32'h44, enc_r(5, 0, 0, 6'h08));          // R9 jr r5
        put_word(32'h48, enc_i(6'h2B, 0, 1, 16'h011C));
        put_word(32'h4C, enc_i(6'h2B, 0, 1, 16'h011C));
        put_word(32'h50, 32'hFC00_0000);                  // R11 unknown
        put_word(32'h54, enc_i(6'h2B, 0, 1, 16'h0124));
        put_word(32'h58, enc_j(6'h02, 26'h16));           // self loop

        for (int ia = 0; ia < 6; ia++) begin
            for (int ib = 0; ib < 6; ib++) begin
                logic [31:0] a, b;
                int wcnt, wexp;
                a = vals[ia]; b = vals[ib]; wcnt = 0;
                rst = 1'b1;
                put_word(32'h100, a);
                put_word(32'h104, b);
                put_word(32'h108, SENT);
                put_word(32'h10C, SENT);
                put_word(32'h110, SENT);
                put_word(32'h114, SENT);
                put_word(32'h118, SENT);
                put_word(32'h11C, SENT);
                put_word(32'h120, 32'h50);
                put_word(32'h124, SENT);
                @(negedge clk);
                rst = 1'b0;
                for (int i = 0; i < RUN_CYC; i++) begin
                    if (i == 0) begin
                        check("R1 reset address", mem_addr, 32'h0);
                        check("R1 reset strobe", {31'd0, mem_we}, 32'h0);
                    end
                    if (i == 3)  check("R2 second fetch address", mem_addr, 32'h4);
                    if (i == 27) check("R6 fetch after beq", mem_addr, (a == b) ? 32'h28 : 32'h24);
                    if (mem_we) wcnt++;
                    @(negedge clk);
                end
                rst = 1'b1;
                wexp = 4 + ((a == b) ? 0 : 1) + (a[31] ? 0 : 1);
                check("R3 addu result", mem[32'h108 >> 2], a + b);
                check("R3 subu result", mem[32'h10C >> 2], a - b);
                check("R10 r0 after write", mem[32'h110 >> 2], 32'h0);
                check("R6 beq fallthrough store", mem[32'h114 >> 2], (a == b) ? SENT : a);
                check("R7 bltz fallthrough store", mem[32'h118 >> 2], a[31] ? SENT : b);
                check("R8 R9 skipped stores", mem[32'h11C >> 2], SENT);
                check("R11 R4 store after nop", mem[32'h124 >> 2], a);
                check("R5 write strobe count", wcnt, wexp);
            end
        end
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule